// File: doc/BRIEF.md
# Flash Sub-ADC Thermometer-to-Binary Encoder

This block turns the raw decision vector of a small flash quantizer into a registered binary level. A strobe captures the comparator outputs into a register, which makes them synchronous with the system clock. A three-input majority filter removes isolated bubbles from the captured vector. The cleaned vector is then encoded into Gray code, and the Gray code is encoded into binary. Because each comparator output feeds exactly one Gray bit, a stray transition can disturb only one bit of the intermediate code. The whole path is built from static gates and registers.

One parameter selects between two variants. The wide variant has 14 comparators and a 4-bit result, with levels 0 to 14; the sixteenth code is left unused as redundancy. The narrow variant has 7 comparators and a 3-bit result. The result and a one-cycle valid pulse appear one clock after the capture.

Top module: `tenc_flash_encoder`

## Requirements
- R1: Parameter STAGE = 0 builds the wide variant: a 14-bit comparator input and a 4-bit code. STAGE = 1 builds the narrow variant: a 7-bit input and a 3-bit code.
- R2: If the captured vector is a clean thermometer, with bits [L-1:0] high and all other bits low (bit 0 is the lowest threshold), the code equals L. This holds for every L from 0 to the comparator count.
- R3: The code never exceeds the comparator count, for any input pattern. In the wide variant the value 15 never appears.
- R4: If latch_i is sampled high at a clock edge, valid_o is high for the cycle after the next edge. It stays high for one cycle only, unless latch_i was high again.
- R5: While latch_i is low, changes on cmp_i have no effect: code_o holds its value and valid_o stays low.
- R6: Take a clean thermometer of level L and flip one bit j. The code is exactly L when j <= L-3 or j >= L+2. For any other j, the code lies within one level of L.
- R7: The reset is synchronous and active low. While it is applied, code_o and valid_o are cleared to zero at each clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| latch_i | input | 1 | Capture strobe for the comparator vector |
| cmp_i | input | NCMP (14 or 7) | Comparator decisions; bit 0 is the lowest threshold |
| code_o | output | CODE_W (4 or 3) | Registered binary level |
| valid_o | output | 1 | One-cycle pulse marking a new code |

## Verification
The hardest cases to reach are the corrupted thermometers: a single flipped bit next to the 1-to-0 edge, and arbitrary non-thermometer patterns that could decode to the unused code 15. The bench reaches both from the ports. It sweeps every level against every flip position and checks the distance rule. It then strobes all 16384 possible 14-bit vectors into the wide variant and checks the range bound on each one. The narrow variant gets the same level and flip sweeps.

// File: rtl/tenc_pkg.sv
`timescale 1ns/1ps
// tenc_pkg: helpers shared by the thermometer encoder.
// Assumes: comparator counts stay below 32, so a 32-bit tap mask is enough.
package tenc_pkg;

    // Comparator count for a stage variant (0 = wide, 1 = narrow).
    function automatic int tenc_cmp_count(input int stage);
        return (stage == 0) ? 14 : 7;
    endfunction

    // Code width needed to hold levels 0..ncmp.
    function automatic int tenc_code_width(input int ncmp);
        return $clog2(ncmp + 1);
    endfunction

    // Number of trailing zero bits of a positive integer.
    function automatic int tenc_trailing_zeros(input int k);
        int v;
        int z;
        v = k;
        z = 0;
        while ((v > 0) && ((v % 2) == 0)) begin
            v = v / 2;
            z = z + 1;
        end
        return z;
    endfunction

    // Thermometer taps that feed one Gray bit.
    // Gray bit b toggles at every level k whose trailing-zero count is b.
    function automatic logic [31:0] tenc_gray_taps(input int bit_idx, input int ncmp);
        logic [31:0] m;
        m = '0;
        for (int k = 1; k <= ncmp; k++) begin
            if (tenc_trailing_zeros(k) == bit_idx) begin
                m[k-1] = 1'b1;
            end
        end
        return m;
    endfunction

endpackage

// File: rtl/tenc_capture.sv
`timescale 1ns/1ps
// tenc_capture: registers the comparator vector when the strobe is high,
// and raises a one-cycle "fresh" flag in the following cycle.
// Assumes: the comparator outputs are settled when the strobe is sampled.
module tenc_capture #(
    parameter int NCMP = 14
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            strobe_i,
    input  logic [NCMP-1:0] cmp_i,
    output logic [NCMP-1:0] therm_o,
    output logic            fresh_o
);

    // Capture register: loads only on a strobe and clears on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            therm_o <= '0;
            fresh_o <= 1'b0;
        end else begin
            fresh_o <= strobe_i;
            if (strobe_i) begin
                therm_o <= cmp_i;
            end
        end
    end

    // R5: with no strobe, the captured vector must not move.
    p_hold_without_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe_i |=> $stable(therm_o));

endmodule

// File: rtl/tenc_bubble_fix.sv
`timescale 1ns/1ps
// tenc_bubble_fix: three-input majority filter over the thermometer.
// Each bit is replaced by the majority of itself and its two neighbours.
// Below bit 0 a virtual 1 is assumed, and above the top bit a virtual 0.
// This removes any single bit that disagrees with both of its neighbours.
// Assumes: purely combinational; the output is registered downstream.
module tenc_bubble_fix #(
    parameter int NCMP = 14
) (
    input  logic [NCMP-1:0] therm_i,
    output logic [NCMP-1:0] therm_o
);

    localparam int EXT_W = NCMP + 2;

    logic [EXT_W-1:0] ext;

    // Pad the vector with the known end values.
    assign ext = {1'b0, therm_i, 1'b1};

    genvar k;
    generate
        for (k = 0; k < NCMP; k++) begin : g_vote
            // Majority vote of positions k-1, k and k+1 (offset by one in ext).
            assign therm_o[k] = (ext[k]   & ext[k+1]) |
                                (ext[k+1] & ext[k+2]) |
                                (ext[k]   & ext[k+2]);
        end
    endgenerate

    // R2: a clean thermometer must pass through the filter unchanged.
    always_comb begin
        if ((therm_i & (therm_i + 1'b1)) == '0) begin
            p_clean_passthrough_r2: assert (therm_o == therm_i);
        end
    end

endmodule

// File: rtl/tenc_therm2gray.sv
`timescale 1ns/1ps
// tenc_therm2gray: encodes a thermometer into Gray code with XOR trees.
// Each thermometer bit feeds exactly one Gray bit, so a single wrong
// comparator output disturbs only one Gray bit.
// Assumes: NCMP < 2**CODE_W.
module tenc_therm2gray
    import tenc_pkg::*;
#(
    parameter int NCMP   = 14,
    parameter int CODE_W = 4
) (
    input  logic [NCMP-1:0]   therm_i,
    output logic [CODE_W-1:0] gray_o
);

    genvar b;
    generate
        for (b = 0; b < CODE_W; b++) begin : g_bit
            localparam logic [31:0] TAPS = tenc_gray_taps(b, NCMP);
            // Parity of the thermometer taps that belong to this Gray bit.
            assign gray_o[b] = ^(therm_i & TAPS[NCMP-1:0]);
        end
    endgenerate

endmodule

// File: rtl/tenc_gray2bin.sv
`timescale 1ns/1ps
// tenc_gray2bin: converts Gray code to binary with a prefix XOR.
// Results above MAXV are clamped to MAXV; the clamp is built only
// when MAXV leaves codes unused.
// Assumes: MAXV <= 2**CODE_W - 1.
module tenc_gray2bin #(
    parameter int CODE_W = 4,
    parameter int MAXV   = 14
) (
    input  logic [CODE_W-1:0] gray_i,
    output logic [CODE_W-1:0] bin_o
);

    localparam int              FULL     = (1 << CODE_W) - 1;
    localparam logic [CODE_W-1:0] MAX_CODE = CODE_W'(MAXV);

    logic [CODE_W-1:0] bin_raw;

    // Prefix XOR, taken from the top bit down.
    always_comb begin
        logic acc;
        acc = 1'b0;
        for (int i = CODE_W - 1; i >= 0; i--) begin
            acc        = acc ^ gray_i[i];
            bin_raw[i] = acc;
        end
    end

    generate
        if (MAXV < FULL) begin : g_clamp
            // Saturate codes that lie beyond the top level.
            assign bin_o = (bin_raw > MAX_CODE) ? MAX_CODE : bin_raw;
        end else begin : g_pass
            assign bin_o = bin_raw;
        end
    endgenerate

endmodule

// File: rtl/tenc_flash_encoder.sv
`timescale 1ns/1ps
// tenc_flash_encoder: top level of the flash sub-ADC encoder.
// Pipeline: capture on strobe -> bubble filter -> Gray -> binary -> output register.
// STAGE 0 = 14 comparators / 4-bit code; STAGE 1 = 7 comparators / 3-bit code.
// Assumes: a synchronous active-low reset, and comparator bit 0 holds the
// lowest threshold.
module tenc_flash_encoder
    import tenc_pkg::*;
#(
    parameter  int STAGE  = 0,
    localparam int NCMP   = tenc_cmp_count(STAGE),
    localparam int CODE_W = tenc_code_width(NCMP)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              latch_i,
    input  logic [NCMP-1:0]   cmp_i,
    output logic [CODE_W-1:0] code_o,
    output logic              valid_o
);

    localparam logic [CODE_W-1:0] TOP_CODE = CODE_W'(NCMP);

    logic [NCMP-1:0]   therm_cap;
    logic [NCMP-1:0]   therm_clean;
    logic [CODE_W-1:0] gray;
    logic [CODE_W-1:0] bin;
    logic              fresh;

    tenc_capture #(.NCMP(NCMP)) u_capture (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe_i (latch_i),
        .cmp_i    (cmp_i),
        .therm_o  (therm_cap),
        .fresh_o  (fresh)
    );

    tenc_bubble_fix #(.NCMP(NCMP)) u_bubble (
        .therm_i (therm_cap),
        .therm_o (therm_clean)
    );

    tenc_therm2gray #(.NCMP(NCMP), .CODE_W(CODE_W)) u_t2g (
        .therm_i (therm_clean),
        .gray_o  (gray)
    );

    tenc_gray2bin #(.CODE_W(CODE_W), .MAXV(NCMP)) u_g2b (
        .gray_i (gray),
        .bin_o  (bin)
    );

    // Output register: loads the new code and raises valid one cycle after a capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_o  <= '0;
            valid_o <= 1'b0;
        end else begin
            valid_o <= fresh;
            if (fresh) begin
                code_o <= bin;
            end
        end
    end

    // R4: a sampled strobe yields valid one clock after the capture edge.
    p_valid_after_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
        latch_i |=> ##1 valid_o);

    // R4: valid never rises without a strobe two edges earlier.
    p_no_spurious_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !latch_i |=> ##1 !valid_o);

    // R5: the code changes only in a cycle that valid marks.
    p_code_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> $stable(code_o));

    // R3: the registered code stays within the level range.
    p_code_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        code_o <= TOP_CODE);

    // R7: a reset cycle leaves code and valid cleared.
    p_reset_clears_r7: assert property (@(posedge clk)
        !rst_n |=> (code_o == '0) && !valid_o);

endmodule

// File: tb/tb_tenc_flash_encoder.sv
`timescale 1ns/1ps
// Bench: drives both variants side by side. Expected values come from
// level arithmetic and the flip-distance rule, not from the design.
module tb_tenc_flash_encoder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        latch = 1'b0;
    logic [13:0] cmp1 = '0;
    logic [6:0]  cmp2 = '0;
    logic [3:0]  code1;
    logic [2:0]  code2;
    logic        valid1;
    logic        valid2;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    tenc_flash_encoder #(.STAGE(0)) dut (
        .clk(clk), .rst_n(rst_n), .latch_i(latch),
        .cmp_i(cmp1), .code_o(code1), .valid_o(valid1)
    );

    tenc_flash_encoder #(.STAGE(1)) dut_s2 (
        .clk(clk), .rst_n(rst_n), .latch_i(latch),
        .cmp_i(cmp2), .code_o(code2), .valid_o(valid2)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Strobe one vector per variant; return after the output edge, on a negedge.
    task automatic strobe(input logic [13:0] v1, input logic [6:0] v2);
        @(negedge clk);
        cmp1  = v1;
        cmp2  = v2;
        latch = 1'b1;
        @(negedge clk);
        latch = 1'b0;
        @(negedge clk);
    endtask

    function automatic logic [13:0] therm14(input int lvl);
        return 14'((1 << lvl) - 1);
    endfunction

    function automatic logic [6:0] therm7(input int lvl);
        return 7'((1 << lvl) - 1);
    endfunction

    function automatic int absdiff(input int a, input int b);
        return (a > b) ? a - b : b - a;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // R7: state while reset is held
        repeat (3) @(negedge clk);
        check(code1 == 4'd0, "R7 reset code wide", int'(code1), 0);
        check(code2 == 3'd0, "R7 reset code narrow", int'(code2), 0);
        check(!valid1 && !valid2, "R7 reset valid", int'(valid1), 0);
        rst_n = 1'b1;

        // R1: port widths of each variant
        check($bits(cmp1) == 14 && $bits(code1) == 4, "R1 wide widths", $bits(code1), 4);
        check($bits(cmp2) == 7 && $bits(code2) == 3, "R1 narrow widths", $bits(code2), 3);

        // R2 / R4: every clean level in both variants, plus the valid pulse shape
        for (int lvl = 0; lvl <= 14; lvl++) begin
            strobe(therm14(lvl), therm7(lvl % 8));
            check(int'(code1) == lvl, "R2 wide level", int'(code1), lvl);
            check(int'(code2) == lvl % 8, "R2 narrow level", int'(code2), lvl % 8);
            check(valid1 && valid2, "R4 valid high after strobe", int'(valid1), 1);
            @(negedge clk);
            check(!valid1 && !valid2, "R4 valid single cycle", int'(valid1), 0);
        end

        // R5: comparator changes without a strobe are ignored
        strobe(therm14(9), therm7(5));
        cmp1 = therm14(2);
        cmp2 = therm7(1);
        repeat (4) @(negedge clk);
        check(code1 == 4'd9, "R5 wide hold", int'(code1), 9);
        check(code2 == 3'd5, "R5 narrow hold", int'(code2), 5);
        check(!valid1 && !valid2, "R5 no valid without strobe", int'(valid1), 0);

        // R4: back-to-back strobes keep valid high on consecutive cycles
        @(negedge clk);
        cmp1 = therm14(3);
        latch = 1'b1;
        @(negedge clk);
        cmp1 = therm14(11);
        @(negedge clk);
        latch = 1'b0;
        check(valid1 && code1 == 4'd3, "R4 back-to-back first", int'(code1), 3);
        @(negedge clk);
        check(valid1 && code1 == 4'd11, "R4 back-to-back second", int'(code1), 11);

        // R6: every single-bit flip, wide variant
        for (int lvl = 0; lvl <= 14; lvl++) begin
            for (int j = 0; j < 14; j++) begin
                strobe(therm14(lvl) ^ (14'd1 << j), 7'd0);
                if ((j <= lvl - 3) || (j >= lvl + 2))
                    check(int'(code1) == lvl, "R6 wide far flip", int'(code1), lvl);
                else
                    check(absdiff(int'(code1), lvl) <= 1, "R6 wide near flip", int'(code1), lvl);
            end
        end

        // R6: every single-bit flip, narrow variant
        for (int lvl = 0; lvl <= 7; lvl++) begin
            for (int j = 0; j < 7; j++) begin
                strobe(14'd0, therm7(lvl) ^ (7'd1 << j));
                if ((j <= lvl - 3) || (j >= lvl + 2))
                    check(int'(code2) == lvl, "R6 narrow far flip", int'(code2), lvl);
                else
                    check(absdiff(int'(code2), lvl) <= 1, "R6 narrow near flip", int'(code2), lvl);
            end
        end

        // R3: all 14-bit patterns stay within 0..14
        for (int v = 0; v < 16384; v++) begin
            strobe(14'(v), 7'(v));
            check(int'(code1) <= 14, "R3 wide range", int'(code1), 14);
        end

        // R7: a reset applied mid-run clears the outputs
        strobe(therm14(12), therm7(6));
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(code1 == 4'd0 && code2 == 3'd0, "R7 mid-run reset code", int'(code1), 0);
        check(!valid1 && !valid2, "R7 mid-run reset valid", int'(valid1), 0);
        rst_n = 1'b1;

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule